// File: doc/BRIEF.md
# Dual-Format Serial Audio Mono Receiver

This block takes a three-wire serial audio stream (bit clock, word clock, serial data) and turns it into one 24-bit two's-complement sample per stereo frame. A static format input chooses between I2S framing, carrying words of 16 to 24 bits, and right-justified framing, carrying 16-bit words. A channel-select input picks either the left or the right word of each frame. The chosen word is presented on a parallel output together with a one-cycle valid strobe, and the other word is dropped.

All three serial lines are treated as asynchronous inputs. They are oversampled in a single system-clock domain that must run well above the bit clock; each bit clock high and low phase must last at least two system-clock cycles. Words shorter than 24 bits are left-aligned, so the sign bit is always at bit 23 of the output. Filtering, de-emphasis and conversion to analog are handled elsewhere. The block only delivers the deserialized, sign-aligned mono sample.

Top module: `sar_mono_rx`

## Requirements
- R1: While reset is asserted and after it is released, the sample output is 0 and the valid strobe is low until the first word is delivered.
- R2: With the format input low (I2S), a word clock low marks the left word and a word clock high marks the right word. Data is taken on bit clock rising edges, MSB first. The MSB is on the second rising edge after a word-clock change. A word of N bits (16 to 24) appears on output bits 23 down to 24-N, and the lower bits are zero.
- R3: In I2S framing, any bit after the 24th of a word does not affect the output sample.
- R4: With the format input high (right-justified), a word clock high marks the left word and a word clock low marks the right word. The last 16 bits taken before each word-clock change form the word, which appears on output bits 23:8, with bits 7:0 zero.
- R5: Right-justified framing works at 32, 48 and 64 bit clocks per frame, and the padding bits ahead of the 16 data bits do not affect the output.
- R6: With channel select high only left words are delivered, and with it low only right words. Words come out in stream order.
- R7: Each delivered word raises the valid strobe for exactly one system-clock cycle. The sample output holds its value between strobes.
- R8: A word is delivered only if the word-clock change that opens it was seen after reset. The block starts out tracking the word-clock-low level, so the first I2S left word after reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Serial word (channel) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| rj_mode_i | input | 1 | Framing select: 0 = I2S, 1 = 16-bit right-justified |
| pick_left_i | input | 1 | Channel select: 1 = left word, 0 = right word |
| sample_o | output | 24 | Selected word, left-aligned two's complement |
| sample_vld_o | output | 1 | One-cycle strobe when sample_o is updated |

## Verification
The hardest case to reach is I2S at 48 bit clocks per frame with 24-bit words. In that case the LSB of each word arrives on the first rising edge after the word clock has already changed, so it must be credited to the word that is ending and not to the next one. The bench builds the serial stream slot by slot from the framing rules: the word clock changes one slot ahead of the MSB, and at 64 clocks per frame the slots after the 24th bit are filled with ones. This makes any misplaced boundary show up as a wrong sample value. Right-justified runs also fill the padding slots with ones, and the bench resets the block before each scenario so that the first-word-drop rule can be checked.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAR_SAMPLE_W = 24;
  localparam int unsigned SAR_RJ_W     = 16;
  localparam int unsigned SAR_SYNC_N   = 2;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } sar_fmt_e;
endpackage

// File: rtl/sar_sync_lane.sv
module sar_sync_lane #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned STAGES = sar_pkg::SAR_SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] lvl_o,
  output logic             rise0_o
);
  logic lane0_prev_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], async_i[g]};
    end else begin : g_single
      assign chain_d = async_i[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= chain_d;
    end
    assign lvl_o[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lane0_prev_q <= 1'b0;
    else         lane0_prev_q <= lvl_o[0];
  end

  assign rise0_o = lvl_o[0] & ~lane0_prev_q;

  // R2: a bit-clock rising edge is seen for one cycle only
  assert_rise_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise0_o |=> !rise0_o);
endmodule

// File: rtl/sar_word_asm.sv
module sar_word_asm
  import sar_pkg::*;
#(
  parameter int unsigned W    = SAR_SAMPLE_W,
  parameter int unsigned RJ_W = SAR_RJ_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_stb_i,
  input  logic         bit_i,
  input  logic         ws_i,
  input  logic         rj_mode_i,
  output logic         done_o,
  output logic         left_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam int unsigned PAD_W = W - RJ_W;

  sar_fmt_e fmt;
  assign fmt = sar_fmt_e'(rj_mode_i);

  logic            ws_d1_q, ws_d1_d;
  logic            ws_last_q, ws_last_d;
  logic            have_q, have_d;
  logic [W-1:0]    acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RJ_W-1:0] sh_q, sh_d;
  logic            eff_ws;
  logic            boundary;

  // I2S words open one bit clock after the word clock moves; RJ words at once
  assign eff_ws   = (fmt == FMT_RJ) ? ws_i : ws_d1_q;
  assign boundary = bit_stb_i && (eff_ws != ws_last_q);

  always_comb begin
    ws_d1_d   = ws_d1_q;
    ws_last_d = ws_last_q;
    have_d    = have_q;
    acc_d     = acc_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    if (bit_stb_i) begin
      ws_d1_d   = ws_i;
      ws_last_d = eff_ws;
      sh_d      = {sh_q[RJ_W-2:0], bit_i};
      if (boundary) begin
        have_d       = 1'b1;
        acc_d        = '0;
        acc_d[W-1]   = bit_i;
        cnt_d        = CNT_W'(1);
      end else if (cnt_q < CNT_W'(W)) begin
        acc_d[W-1-int'(cnt_q)] = bit_i;
        cnt_d                  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_d1_q   <= 1'b0;
      ws_last_q <= 1'b0;
      have_q    <= 1'b0;
      acc_q     <= '0;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else begin
      ws_d1_q   <= ws_d1_d;
      ws_last_q <= ws_last_d;
      have_q    <= have_d;
      acc_q     <= acc_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
    end
  end

  assign done_o = boundary && have_q;
  assign left_o = (fmt == FMT_RJ) ? ws_last_q : ~ws_last_q;
  assign word_o = (fmt == FMT_RJ) ? {sh_q, {PAD_W{1'b0}}} : acc_q;

  // R3: the fill position never runs past the last output bit
  assert_cnt_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(W));
  // R8: no word completes before an opening boundary has been seen
  assert_open_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(have_d));
endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg #(
  parameter int unsigned W = sar_pkg::SAR_SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic         left_i,
  input  logic [W-1:0] word_i,
  input  logic         pick_left_i,
  output logic [W-1:0] sample_o,
  output logic         vld_o
);
  logic         take;
  logic [W-1:0] sample_q, sample_d;
  logic         vld_q;

  assign take = done_i && (left_i == pick_left_i);

  always_comb begin
    sample_d = sample_q;
    if (take) sample_d = word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      sample_q <= sample_d;
      vld_q    <= take;
    end
  end

  assign sample_o = sample_q;
  assign vld_o    = vld_q;

  // R7: strobe lasts a single cycle
  assert_vld_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  // R7: sample only moves together with the strobe
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_o) |-> vld_o);
endmodule

// File: rtl/sar_mono_rx.sv
module sar_mono_rx
  import sar_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAR_SAMPLE_W,
  parameter int unsigned RJ_W     = SAR_RJ_W,
  parameter int unsigned SYNC_N   = SAR_SYNC_N
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  input  logic                rj_mode_i,
  input  logic                pick_left_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o
);
  localparam int unsigned LANES = 3;

  logic [LANES-1:0]    lvl;
  logic                bclk_rise;
  logic                done;
  logic                left;
  logic [SAMPLE_W-1:0] word;

  sar_sync_lane #(
    .LANES (LANES),
    .STAGES(SYNC_N)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({sdata_i, wclk_i, bclk_i}),
    .lvl_o  (lvl),
    .rise0_o(bclk_rise)
  );

  sar_word_asm #(
    .W   (SAMPLE_W),
    .RJ_W(RJ_W)
  ) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_stb_i(bclk_rise),
    .bit_i    (lvl[2]),
    .ws_i     (lvl[1]),
    .rj_mode_i(rj_mode_i),
    .done_o   (done),
    .left_o   (left),
    .word_o   (word)
  );

  sar_out_reg #(
    .W(SAMPLE_W)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .left_i     (left),
    .word_i     (word),
    .pick_left_i(pick_left_i),
    .sample_o   (sample_o),
    .vld_o      (sample_vld_o)
  );

  // R6: a word is delivered only following a bit-clock rising edge
  assert_vld_after_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |-> $past(bclk_rise));
endmodule

// File: tb/sar_mono_rx_tb.sv
module sar_mono_rx_tb_top;
  localparam int NFR = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic        rj_mode = 1'b0, pick_left = 1'b0;
  logic [23:0] sample_o;
  logic        sample_vld_o;

  int checks = 0;
  int errors = 0;

  logic [23:0] got_q[$];
  logic [23:0] last_s;
  logic        prev_vld;
  int          dbl, holdbad;

  always #5 clk = ~clk;

  sar_mono_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .wclk_i(wclk),
    .sdata_i(sdata), .rj_mode_i(rj_mode), .pick_left_i(pick_left),
    .sample_o(sample_o), .sample_vld_o(sample_vld_o)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (sample_vld_o) begin
        got_q.push_back(sample_o);
        if (prev_vld) dbl++;
      end else if (sample_o !== last_s) begin
        holdbad++;
      end
    end
    last_s   = sample_o;
    prev_vld = sample_vld_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit rj, input bit pl);
    rst_ni    = 1'b0;
    rj_mode   = rj;
    pick_left = pl;
    bclk = 1'b0; wclk = 1'b0; sdata = 1'b0;
    #40;
    chk(sample_o == 24'h0 && !sample_vld_o, "R1 reset state",
        {7'd0, sample_vld_o, sample_o}, 32'h0);
    rst_ni = 1'b1;
    #40;
  endtask

  task automatic drive_slot(input logic ws, input logic d);
    wclk  = ws;
    sdata = d;
    #40;
    bclk = 1'b1;
    #40;
    bclk = 1'b0;
  endtask

  function automatic logic i2s_bit(input logic [31:0] w, input int n, input int p);
    if (p < n)   return w[n-1-p];
    if (p >= 24) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_case(input string tag, input bit rj, input int bpf,
                          input int nbits, input bit pl, input int seed);
    logic [31:0] lw[NFR];
    logic [31:0] rw[NFR];
    logic [23:0] exp_q[$];
    int n, h, k, hl;
    logic ws, d;
    logic [31:0] mask, prev;
    n    = rj ? 16 : nbits;
    mask = (32'h1 << n) - 32'h1;
    hl   = bpf / 2;
    for (int f = 0; f < NFR; f++) begin
      lw[f] = (32'h9E3779B9 * (2*f + 1 + seed) + 32'h1234567) & mask;
      rw[f] = (32'h85EBCA6B * (2*f + 2 + seed) + 32'h0ABCDEF) & mask;
    end
    do_reset(rj, pl);
    got_q.delete();
    dbl = 0;
    holdbad = 0;
    for (int f = 0; f < NFR; f++) begin
      for (int j = 0; j < bpf; j++) begin
        h = (j >= hl) ? 1 : 0;
        k = j - h*hl;
        if (rj) begin
          ws = (h == 0);
          if (k >= hl - 16) d = (h ? rw[f][15-(k-(hl-16))] : lw[f][15-(k-(hl-16))]);
          else              d = 1'b1;
        end else begin
          ws = (h == 1);
          if (k == 0) begin
            prev = h ? lw[f] : ((f == 0) ? 32'h0 : rw[f-1]);
            d = i2s_bit(prev, n, hl - 1);
          end else begin
            d = i2s_bit(h ? rw[f] : lw[f], n, k - 1);
          end
        end
        drive_slot(ws, d);
      end
    end
    if (rj) begin
      drive_slot(1'b1, 1'b1);
    end else begin
      drive_slot(1'b0, i2s_bit(rw[NFR-1], n, hl - 1));
      drive_slot(1'b0, 1'b0);
    end
    #300;
    for (int f = 0; f < NFR; f++) begin
      if (!rj && pl && f == 0) continue;
      if (rj) exp_q.push_back(pl ? {lw[f][15:0], 8'h00} : {rw[f][15:0], 8'h00});
      else    exp_q.push_back(24'((pl ? lw[f] : rw[f]) << (24 - n)));
    end
    chk(got_q.size() == exp_q.size(), {tag, " word count R6 R8"},
        got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {tag, " sample value"}, {8'h0, got_q[i]},
          {8'h0, exp_q[i]});
    chk(dbl == 0, {tag, " R7 single-cycle strobe"}, dbl, 0);
    chk(holdbad == 0, {tag, " R7 hold between strobes"}, holdbad, 0);
  endtask

  initial begin
    #2;
    // R2 R3 R8: I2S 24-bit, ones after bit 24, left picked (first left dropped)
    run_case("R2 R3 R8 i2s64x24 left", 1'b0, 64, 24, 1'b1, 1);
    // R2: 24-bit word whose LSB follows the word-clock change
    run_case("R2 i2s48x24 right", 1'b0, 48, 24, 1'b0, 2);
    // R2 R6: 16-bit words, zero filled
    run_case("R2 R6 i2s48x16 right", 1'b0, 48, 16, 1'b0, 3);
    run_case("R2 R6 i2s64x20 left", 1'b0, 64, 20, 1'b1, 4);
    // R4 R5: right-justified at all frame lengths
    run_case("R4 R5 rj32 left", 1'b1, 32, 16, 1'b1, 5);
    run_case("R4 R5 rj64 right", 1'b1, 64, 16, 1'b0, 6);
    run_case("R4 R5 R6 rj48 left", 1'b1, 48, 16, 1'b1, 7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule